// File: doc/BRIEF.md
# Programmable Duty-Cycle Pulse Generator

The block takes a clock of unknown frequency and unknown duty cycle and produces a clock at the same frequency. The high time of the output is a programmed fraction of the input period. A fast reference clock `clk` samples the incoming clock. A counter records how many reference cycles fit into one input period, and that count serves as the time measurement. A shift-and-add multiplier scales the count by a 4-bit duty setting `k` and divides the result by 16, so no lookup table is needed.

The resulting delay is split into a coarse code and a fine code. The coarse code counts groups of four reference cycles and the fine code counts single cycles. Two chained counter stages use these codes to time the high phase of the output pulse. Output pulses are only produced once the period measurement is stable, and the lock flag reports that state.

Top module: `duty_pulse_gen`

## Requirements
- R1: Once locked with a steady input period of P reference cycles and duty setting k, the delay code `coarse_code*4 + fine_code` equals floor(P*k/16).
- R2: `fine_code` is the low 2 bits of the delay code and `coarse_code` is the remaining upper bits, each coarse unit worth 4 fine units (for example, delay 13 gives coarse 3 and fine 1).
- R3: While locked, each output pulse stays high for exactly floor(P*k/16) reference cycles, for every k from 5 to 11 (31.25% to 68.75% in 6.25% steps).
- R4: The output high time does not depend on the input high time, for input duty cycles between 30% and 70%.
- R5: The output rises at a fixed latency from each input rising edge. With the default two synchronizer stages, it goes high after the fifth `clk` rising edge, counting from the first edge that samples `in_clk` high.
- R6: `locked` rises only on an input rising edge that completes the second of two consecutive period measurements differing by at most one count. `pulse_out` stays low until then.
- R7: A duty setting below 5 is used as 5 and a setting above 11 is used as 11.
- R8: `duty_k` is captured only on an input rising edge. A change between edges leaves the delay codes unchanged until after the next input rising edge.
- R9: If `in_clk` shows no rising edge for 1023 reference cycles (2^CNT_W - 1), `locked` drops and measurement restarts. It must not drop before then.
- R10: A period measurement that differs from the previous one by more than one count clears `locked`. No pulse starts while `locked` is low.
- R11: Synchronous reset clears the output, the lock and the codes. Deasserting `en` clears the lock and holds the output low, and the block relocks once `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that samples the input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low clears measurement and lock |
| in_clk | input | 1 | Incoming clock, asynchronous to `clk` |
| duty_k | input | 4 | Duty setting in sixteenths of the period |
| pulse_out | output | 1 | Regenerated clock with programmed high time |
| locked | output | 1 | Period measurement is stable |
| coarse_code | output | CNT_W-2 | Delay code, groups of four reference cycles |
| fine_code | output | 2 | Delay code, single reference cycles |

## Verification
The sharpest coincidence occurs when a new input rising edge both completes a period measurement and schedules the next output pulse. If that measurement breaks lock, the pulse scheduled from the same edge must be suppressed. The bench provokes this by stepping the input period between measurements. A monitor then judges that `pulse_out` is never high while `locked` has been low for more than one cycle, and that a loss of lock was actually seen. A second case is a duty setting changed in the middle of a period. The bench makes that change just after a pulse starts and requires the codes to hold until the following input edge.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  localparam int DUTY_W   = 4;
  localparam int DUTY_MIN = 5;
  localparam int DUTY_MAX = 11;
  localparam int DUTY_MID = 8;

  typedef enum logic [1:0] {
    DS_IDLE   = 2'd0,
    DS_COARSE = 2'd1,
    DS_FINE   = 2'd2
  } dstage_e;

  function automatic logic [DUTY_W-1:0] clamp_duty(input logic [DUTY_W-1:0] k);
    if (k < DUTY_W'(DUTY_MIN))      return DUTY_W'(DUTY_MIN);
    else if (k > DUTY_W'(DUTY_MAX)) return DUTY_W'(DUTY_MAX);
    else                            return k;
  endfunction

endpackage

// File: rtl/dpg_edge_sync.sv
module dpg_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  // synchronizer chain, stage 0 samples the asynchronous input
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= 1'b0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[SYNC_STAGES-1];
  end

  assign rise = chain_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/dpg_period_meter.sv
module dpg_period_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise,
  output logic [CNT_W-1:0] period,
  output logic             locked
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] meas;
  logic             seen_q;
  logic             have_prev_q;
  logic             lock_q;
  logic             close;
  logic [CNT_W:0]   a_ext;
  logic [CNT_W:0]   b_ext;

  assign meas  = cnt_q + 1'b1;
  assign a_ext = {1'b0, meas};
  assign b_ext = {1'b0, period_q};
  // new measurement within one count of the previous one
  assign close = (a_ext == b_ext) || (a_ext == b_ext + 1'b1) || (a_ext + 1'b1 == b_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      period_q    <= '0;
      seen_q      <= 1'b0;
      have_prev_q <= 1'b0;
      lock_q      <= 1'b0;
    end else if (!en) begin
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      have_prev_q <= 1'b0;
      lock_q      <= 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      // no edge within the counting range: restart from scratch
      cnt_q       <= '0;
      seen_q      <= 1'b0;
      have_prev_q <= 1'b0;
      lock_q      <= 1'b0;
    end else if (rise) begin
      cnt_q <= '0;
      if (!seen_q) begin
        seen_q <= 1'b1;
      end else begin
        period_q    <= meas;
        have_prev_q <= 1'b1;
        lock_q      <= have_prev_q && close;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign period = period_q;
  assign locked = lock_q;

endmodule

// File: rtl/dpg_duty_scaler.sv
module dpg_duty_scaler
  import dpg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [CNT_W-1:0]  period,
  output logic [DUTY_W-1:0] duty_q,
  output logic [CNT_W-1:0]  delay_q,
  output logic              start_q
);

  localparam int PROD_W = CNT_W + DUTY_W;

  logic [DUTY_W-1:0] k_q;
  logic              rise_d_q;
  logic [PROD_W-1:0] part [DUTY_W];
  logic [PROD_W-1:0] prod;

  // one shifted copy of the period per set bit of the duty setting
  for (genvar i = 0; i < DUTY_W; i++) begin : g_pp
    assign part[i] = k_q[i] ? (PROD_W'(period) << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < DUTY_W; i++) prod = prod + part[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q      <= DUTY_W'(DUTY_MID);
      rise_d_q <= 1'b0;
      start_q  <= 1'b0;
      delay_q  <= '0;
    end else begin
      rise_d_q <= rise;
      start_q  <= rise_d_q;
      delay_q  <= prod[PROD_W-1:DUTY_W];
      if (rise) k_q <= clamp_duty(duty_in);
    end
  end

  assign duty_q = k_q;

endmodule

// File: rtl/dpg_delay_stages.sv
module dpg_delay_stages
  import dpg_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int FINE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             locked,
  input  logic             start,
  input  logic [CNT_W-1:0] delay,
  output logic             pulse
);

  localparam int COARSE_W = CNT_W - FINE_W;
  localparam logic [FINE_W-1:0]   QMAX = '1;
  localparam logic [COARSE_W-1:0] C_ONE = COARSE_W'(1);
  localparam logic [FINE_W-1:0]   F_ONE = FINE_W'(1);

  dstage_e             st_q;
  logic [COARSE_W-1:0] crs_q;
  logic [FINE_W-1:0]   sub_q;
  logic [FINE_W-1:0]   fin_q;
  logic                pulse_q;
  logic [COARSE_W-1:0] d_crs;
  logic [FINE_W-1:0]   d_fin;

  assign d_crs = delay[CNT_W-1:FINE_W];
  assign d_fin = delay[FINE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q    <= DS_IDLE;
      crs_q   <= '0;
      sub_q   <= '0;
      fin_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start && locked && (delay != '0)) begin
      pulse_q <= 1'b1;
      crs_q   <= d_crs;
      fin_q   <= d_fin;
      sub_q   <= '0;
      st_q    <= (d_crs != '0) ? DS_COARSE : DS_FINE;
    end else if (!locked) begin
      pulse_q <= 1'b0;
      st_q    <= DS_IDLE;
    end else begin
      case (st_q)
        DS_COARSE: begin
          if (sub_q == QMAX) begin
            sub_q <= '0;
            crs_q <= crs_q - 1'b1;
            if (crs_q == C_ONE) begin
              if (fin_q == '0) begin
                pulse_q <= 1'b0;
                st_q    <= DS_IDLE;
              end else begin
                st_q <= DS_FINE;
              end
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        DS_FINE: begin
          fin_q <= fin_q - 1'b1;
          if (fin_q == F_ONE) begin
            pulse_q <= 1'b0;
            st_q    <= DS_IDLE;
          end
        end
        default: begin
          pulse_q <= 1'b0;
        end
      endcase
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/duty_pulse_gen.sv
module duty_pulse_gen
  import dpg_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int FINE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_clk,
  input  logic [3:0]              duty_k,
  output logic                    pulse_out,
  output logic                    locked,
  output logic [CNT_W-FINE_W-1:0] coarse_code,
  output logic [FINE_W-1:0]       fine_code
);

  logic              rise;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  delay_q;
  logic              start_q;
  logic [DUTY_W-1:0] duty_q;

  dpg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (in_clk),
    .rise     (rise)
  );

  dpg_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .rise   (rise),
    .period (period),
    .locked (locked)
  );

  dpg_duty_scaler #(.CNT_W(CNT_W)) u_scale (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .duty_in (duty_k),
    .period  (period),
    .duty_q  (duty_q),
    .delay_q (delay_q),
    .start_q (start_q)
  );

  dpg_delay_stages #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .locked (locked),
    .start  (start_q),
    .delay  (delay_q),
    .pulse  (pulse_out)
  );

  assign coarse_code = delay_q[CNT_W-1:FINE_W];
  assign fine_code   = delay_q[FINE_W-1:0];

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int CNT_W  = 10,
  parameter int FINE_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rise,
  input logic                    locked,
  input logic                    pulse_out,
  input logic [CNT_W-FINE_W-1:0] coarse_code,
  input logic [FINE_W-1:0]       fine_code,
  input logic [3:0]              duty_q
);

  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W:0]   gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else     hi_cnt <= pulse_out ? hi_cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                gap_cnt <= '0;
    else if (rise)          gap_cnt <= '0;
    else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
  end

  // R6 / R10: no high output once lock has been low for a full cycle
  p_low_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
    (!locked && !$past(locked)) |-> !pulse_out);

  // R6: lock is only gained on an input edge
  p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rise));

  // R8: codes move only two cycles after an input edge
  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable({coarse_code, fine_code}) |-> $past(rise, 2));

  // R3: high phase never exceeds the delay code
  p_width_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> (hi_cnt < {coarse_code, fine_code}));

  // R7: captured setting always in the legal range
  p_duty_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (duty_q >= 4'd5) && (duty_q <= 4'd11));

  // R9: lock cannot survive a gap beyond the counting range
  p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
    (gap_cnt > {1'b0, {CNT_W{1'b1}}}) |-> !locked);

endmodule

bind duty_pulse_gen dpg_checker #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rise        (rise),
  .locked      (locked),
  .pulse_out   (pulse_out),
  .coarse_code (coarse_code),
  .fine_code   (fine_code),
  .duty_q      (duty_q)
);

// File: tb/sim_duty_pulse_gen.sv
module sim_duty_pulse_gen;

  localparam int CNT_W  = 10;
  localparam int FINE_W = 2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    en  = 1'b0;
  logic                    in_clk = 1'b0;
  logic [3:0]              duty_k = 4'd8;
  logic                    pulse_out;
  logic                    locked;
  logic [CNT_W-FINE_W-1:0] coarse_code;
  logic [FINE_W-1:0]       fine_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int gen_per = 40;
  int gen_hi = 20;
  bit gen_run = 1'b0;
  int ph = 0;
  int last_rise_cyc = 0;
  int bad_cnt = 0;
  bit saw_unlock = 1'b0;
  bit prev_lock = 1'b0;
  bit done = 1'b0;

  duty_pulse_gen #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .in_clk(in_clk), .duty_k(duty_k),
    .pulse_out(pulse_out), .locked(locked),
    .coarse_code(coarse_code), .fine_code(fine_code)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // input clock generator, driven away from the active edge
  always @(negedge clk) begin
    if (gen_run) begin
      if (ph == 0) begin
        in_clk <= 1'b1;
        last_rise_cyc <= cyc;
      end
      if (ph == gen_hi) in_clk <= 1'b0;
      ph <= (ph >= gen_per - 1) ? 0 : ph + 1;
    end else begin
      in_clk <= 1'b0;
      ph <= 0;
    end
  end

  // monitor for output while unlocked (R6, R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (pulse_out && !locked && !prev_lock) bad_cnt <= bad_cnt + 1;
      if (prev_lock && !locked && en) saw_unlock <= 1'b1;
    end
    prev_lock <= locked;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int code_val();
    return int'(coarse_code) * 4 + int'(fine_code);
  endfunction

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_lock();
    int t = 0;
    wait_cycles(3 * gen_per);
    while (!locked && t < 20 * gen_per) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic measure_high(output int w, output int lat);
    do @(negedge clk); while (pulse_out !== 1'b0);
    do @(negedge clk); while (pulse_out !== 1'b1);
    lat = cyc - last_rise_cyc;
    w = 0;
    while (pulse_out === 1'b1) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R11 pulse_out after reset", int'(pulse_out), 0);
    chk("R11 locked after reset", int'(locked), 0);
    chk("R11 coarse after reset", int'(coarse_code), 0);
    chk("R11 fine after reset", int'(fine_code), 0);
  endtask

  task automatic t_basic_lock();
    int w, lat;
    duty_k = 4'd8; gen_per = 40; gen_hi = 20;
    en = 1'b1; gen_run = 1'b1;
    wait_lock();
    chk("R6 lock after stable period", int'(locked), 1);
    chk("R1 delay code P=40 k=8", code_val(), 20);
    chk("R2 coarse part of 20", int'(coarse_code), 5);
    measure_high(w, lat);
    chk("R3 high time P=40 k=8", w, 20);
    chk("R5 rise latency", lat, 5);
  endtask

  task automatic t_steps();
    int w, lat;
    duty_k = 4'd5; gen_per = 44; gen_hi = 22;
    wait_lock();
    chk("R10 lock lost on period step", int'(saw_unlock), 1);
    chk("R2 coarse of 13", int'(coarse_code), 3);
    chk("R2 fine of 13", int'(fine_code), 1);
    measure_high(w, lat);
    chk("R3 high time k=5", w, 13);
    duty_k = 4'd11;
    wait_cycles(3 * gen_per);
    chk("R1 delay code P=44 k=11", code_val(), 30);
    measure_high(w, lat);
    chk("R3 high time k=11", w, 30);
  endtask

  task automatic t_input_duty();
    int w, lat;
    duty_k = 4'd8; gen_hi = 13;
    wait_cycles(3 * gen_per);
    measure_high(w, lat);
    chk("R4 high time with 30% input", w, 22);
    gen_hi = 31;
    wait_cycles(3 * gen_per);
    measure_high(w, lat);
    chk("R4 high time with 70% input", w, 22);
  endtask

  task automatic t_clamp();
    int w, lat;
    duty_k = 4'd2;
    wait_cycles(3 * gen_per);
    chk("R7 low setting clamps to 5", code_val(), 13);
    duty_k = 4'd15;
    wait_cycles(3 * gen_per);
    chk("R7 high setting clamps to 11", code_val(), 30);
    measure_high(w, lat);
    chk("R7 high time with clamped 11", w, 30);
  endtask

  task automatic t_latch();
    duty_k = 4'd8;
    wait_cycles(3 * gen_per);
    do @(negedge clk); while (pulse_out !== 1'b0);
    do @(negedge clk); while (pulse_out !== 1'b1);
    duty_k = 4'd11;
    wait_cycles(4);
    chk("R8 code held mid-period", code_val(), 22);
    wait_cycles(gen_per + 4);
    chk("R8 code updated after edge", code_val(), 30);
  endtask

  task automatic t_enable();
    int hi_seen = 0;
    en = 1'b0;
    wait_cycles(2);
    chk("R11 lock cleared by enable low", int'(locked), 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pulse_out) hi_seen++;
    end
    chk("R11 output held low while disabled", hi_seen, 0);
    en = 1'b1;
    wait_lock();
    chk("R11 relock after enable", int'(locked), 1);
  endtask

  task automatic t_timeout();
    gen_run = 1'b0;
    wait_cycles(900);
    chk("R9 lock kept inside range", int'(locked), 1);
    wait_cycles(200);
    chk("R9 lock dropped after gap", int'(locked), 0);
    chk("R9 output low after gap", int'(pulse_out), 0);
  endtask

  initial begin
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_lock();
    t_steps();
    t_input_duty();
    t_clamp();
    t_latch();
    t_enable();
    t_timeout();
    chk("R10 no pulse while unlocked", bad_cnt, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule